// File: doc/BRIEF.md
# Reference Clock Pre-Divider

This block brings each of several reference inputs down to the rate a downstream digital PLL can accept. Each reference arrives as a level sampled in the system clock domain. The block turns every active edge into work for a per-channel divider chain. Each channel emits a one-cycle enable pulse on `out_pulse` each time its chain completes a division.

A channel's chain has three stages. An optional fast prescaler, present on two channels only, divides by 4 or 5. A programmable divider follows, with a 15-bit factor F that yields one output per F+1 inputs. A fixed-ratio stage brings a known nominal rate down to 8 kHz. Two per-channel bits steer the path. Low-rate references (8, 4 or 2 kHz), and the two fixed 8 kHz channels, skip the whole chain. They can pick the falling edge as the active one.

Divisors are loaded indirectly through a small byte-wide write port. Software first writes a channel number, then the low byte of the factor, then the high byte. The high-byte write commits all 15 bits to that channel at once. A running divider takes up a new factor only when its current count reaches zero.

Top module: `ref_prediv`

## Requirements
- R1: After reset, `out_pulse` is all zero and every stored factor is 0, so a channel routed through its programmable divider passes every input edge.
- R2: Channels 0 and 1 always bypass the whole chain, whatever their frequency code and path bits: each active edge gives one pulse, one clock later.
- R3: On any channel, frequency codes 4'h0 (8 kHz), 4'h1 (4 kHz) and 4'h2 (2 kHz) bypass the whole chain, the fast prescaler included. All other codes use the chain.
- R4: In bypass, `invert` set makes the falling edge the active edge instead of the rising edge. Outside bypass, the rising edge is always used and `invert` has no effect.
- R5: On channels HF_CH_A and HF_CH_B, the 2-bit prescaler select gives divide-by-4 for 2'b01 and divide-by-5 for 2'b10. Codes 2'b00 and 2'b11 bypass the prescaler.
- R6: With `use_divn` set, a stored factor F yields exactly one output pulse for every F+1 pulses entering the programmable divider.
- R7: Register writes use address 0 for the channel select (data[3:0]) and address 1 for the low factor byte. Address 2 takes factor bits [14:8] from data[6:0] and commits the full factor to the selected channel. A low-byte write alone changes no channel.
- R8: A stored factor stays until a new commit to the same channel. Commits to other channels leave it unchanged.
- R9: A factor committed while a division is in progress takes effect only after that division ends, so no shortened output period occurs.
- R10: With `use_lock` set and `use_divn` clear, the channel divides the chain input by LK_KHZ/8, a per-channel parameter.
- R11: With both path bits clear, only the prescaler (if any) divides. With both set, the programmable divider is used.
- R12: A commit while the channel select is NUM_CH or greater changes no stored factor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_clk | input | NUM_CH | Sampled reference levels, one per channel |
| freq_code | input | NUM_CH x 4 | Per-channel target-rate code |
| hf_sel_a | input | 2 | Prescaler select for channel HF_CH_A |
| hf_sel_b | input | 2 | Prescaler select for channel HF_CH_B |
| use_divn | input | NUM_CH | Route through the programmable divider |
| use_lock | input | NUM_CH | Route through the fixed 8 kHz stage |
| invert | input | NUM_CH | Falling edge active in bypass |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 select, 1 low byte, 2 high byte and commit |
| wr_data | input | 8 | Register write data |
| out_pulse | output | NUM_CH | One-cycle divided enable per channel |

## Verification
The assertions assume `in_clk` changes at most once per system clock and is known from the first clock after reset. They also assume the write port presents a known address whenever `wr_en` is high. The stimulus drives every reference level and write strobe on the falling clock edge. It holds each level for at least two cycles. It changes path bits and prescaler selects only while the affected channel is idle. Every test window spans a whole multiple of the division ratio, so each counter returns to zero before the next test.

// File: rtl/prediv_pkg.sv
package prediv_pkg;

  // Register addresses of the divisor write port
  localparam logic [1:0] RA_CHSEL = 2'd0;
  localparam logic [1:0] RA_LOW   = 2'd1;
  localparam logic [1:0] RA_HIGH  = 2'd2;

  // Fast prescaler select codes
  localparam logic [1:0] HF_DIV4 = 2'b01;
  localparam logic [1:0] HF_DIV5 = 2'b10;

  // Frequency codes that request whole-chain bypass
  localparam logic [3:0] FC_8K = 4'h0;
  localparam logic [3:0] FC_4K = 4'h1;
  localparam logic [3:0] FC_2K = 4'h2;

  function automatic logic is_low_rate(input logic [3:0] code);
    return (code == FC_8K) || (code == FC_4K) || (code == FC_2K);
  endfunction

endpackage

// File: rtl/prediv_stage.sv
// Down-counting pulse divider; reload value is sampled only at terminal count.
module prediv_stage #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick_in,
  input  logic [CNT_W-1:0] reload,
  output logic             tick_out
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign tick_out = en & tick_in & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= at_zero ? reload : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/prediv_divreg.sv
// Indirect divisor store: select, low byte, then high byte commits.
module prediv_divreg
  import prediv_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DIV_W  = 15,
  parameter int SEL_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_addr,
  input  logic [7:0]                    wr_data,
  output logic [SEL_W-1:0]              sel_q,
  output logic [NUM_CH-1:0][DIV_W-1:0]  div_q
);

  localparam int HI_W = DIV_W - 8;

  logic [7:0]       lo_q;
  logic [DIV_W-1:0] mem_q [NUM_CH];
  logic             commit;
  logic             unused_bits;

  assign commit      = wr_en && (wr_addr == RA_HIGH);
  assign unused_bits = ^{wr_data[7:HI_W], wr_data[7:SEL_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      lo_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == RA_CHSEL) sel_q <= wr_data[SEL_W-1:0];
      if (wr_addr == RA_LOW)   lo_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (rst) begin
        mem_q[c] <= '0;
      end else if (commit && (sel_q == SEL_W'(c))) begin
        mem_q[c] <= {wr_data[HI_W-1:0], lo_q};
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign div_q[c] = mem_q[c];
  end

endmodule

// File: rtl/prediv_chan.sv
// One channel: edge pick, optional prescaler, divider, 8 kHz stage, output register.
module prediv_chan
  import prediv_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int LK_W      = 16,
  parameter bit HAS_HF    = 1'b0,
  parameter bit FIXED_8K  = 1'b0,
  parameter int LK_RELOAD = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_lvl,
  input  logic [3:0]       freq_code,
  input  logic [1:0]       hf_sel,
  input  logic             use_divn,
  input  logic             use_lock,
  input  logic             invert,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_out
);

  logic lvl_q;
  logic rise, fall;
  logic auto_byp, byp_tick, chain_in;
  logic hf_on, hf_div_tick, hf_tick;
  logic dv_tick, lk_tick, path_tick;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= in_lvl;
  end

  assign rise     = in_lvl & ~lvl_q;
  assign fall     = ~in_lvl & lvl_q;
  assign auto_byp = FIXED_8K | is_low_rate(freq_code);
  assign byp_tick = invert ? fall : rise;
  assign chain_in = rise & ~auto_byp;

  assign hf_on = HAS_HF && ((hf_sel == HF_DIV4) || (hf_sel == HF_DIV5));

  if (HAS_HF) begin : g_hf
    logic [2:0] hf_reload;
    assign hf_reload = (hf_sel == HF_DIV5) ? 3'd4 : 3'd3;
    prediv_stage #(.CNT_W(3)) u_hf (
      .clk      (clk),
      .rst      (rst),
      .en       (hf_on & ~auto_byp),
      .tick_in  (chain_in),
      .reload   (hf_reload),
      .tick_out (hf_div_tick)
    );
  end else begin : g_no_hf
    assign hf_div_tick = 1'b0;
  end

  assign hf_tick = hf_on ? hf_div_tick : chain_in;

  prediv_stage #(.CNT_W(DIV_W)) u_divn (
    .clk      (clk),
    .rst      (rst),
    .en       (use_divn & ~auto_byp),
    .tick_in  (hf_tick),
    .reload   (div_val),
    .tick_out (dv_tick)
  );

  prediv_stage #(.CNT_W(LK_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .en       (use_lock & ~use_divn & ~auto_byp),
    .tick_in  (hf_tick),
    .reload   (LK_W'(LK_RELOAD)),
    .tick_out (lk_tick)
  );

  assign path_tick = use_divn ? dv_tick : (use_lock ? lk_tick : hf_tick);

  always_ff @(posedge clk) begin
    if (rst) tick_out <= 1'b0;
    else     tick_out <= auto_byp ? byp_tick : path_tick;
  end

endmodule

// File: rtl/ref_prediv.sv
module ref_prediv
  import prediv_pkg::*;
#(
  parameter int          NUM_CH    = 6,
  parameter int          NUM_FIXED = 2,
  parameter int          DIV_W     = 15,
  parameter int          SEL_W     = 4,
  parameter int          LK_W      = 16,
  parameter int          HF_CH_A   = 4,
  parameter int          HF_CH_B   = 5,
  parameter int unsigned LK_KHZ [NUM_CH] = '{8, 8, 24, 48, 32, 40}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       in_clk,
  input  logic [NUM_CH-1:0][3:0]  freq_code,
  input  logic [1:0]              hf_sel_a,
  input  logic [1:0]              hf_sel_b,
  input  logic [NUM_CH-1:0]       use_divn,
  input  logic [NUM_CH-1:0]       use_lock,
  input  logic [NUM_CH-1:0]       invert,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [7:0]              wr_data,
  output logic [NUM_CH-1:0]       out_pulse
);

  logic [SEL_W-1:0]             sel_q;
  logic [NUM_CH-1:0][DIV_W-1:0] div_q;

  prediv_divreg #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W),
    .SEL_W  (SEL_W)
  ) u_divreg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel_q   (sel_q),
    .div_q   (div_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit HAS_HF = (c == HF_CH_A) || (c == HF_CH_B);
    localparam bit FIXED  = (c < NUM_FIXED);
    localparam int RELOAD = int'(LK_KHZ[c] / 8) - 1;

    logic [1:0] ch_hf_sel;
    assign ch_hf_sel = (c == HF_CH_A) ? hf_sel_a :
                       (c == HF_CH_B) ? hf_sel_b : 2'b00;

    prediv_chan #(
      .DIV_W     (DIV_W),
      .LK_W      (LK_W),
      .HAS_HF    (HAS_HF),
      .FIXED_8K  (FIXED),
      .LK_RELOAD (RELOAD)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .in_lvl    (in_clk[c]),
      .freq_code (freq_code[c]),
      .hf_sel    (ch_hf_sel),
      .use_divn  (use_divn[c]),
      .use_lock  (use_lock[c]),
      .invert    (invert[c]),
      .div_val   (div_q[c]),
      .tick_out  (out_pulse[c])
    );
  end

endmodule

// File: rtl/prediv_chk.sv
module prediv_chk #(
  parameter int NUM_CH    = 6,
  parameter int NUM_FIXED = 2,
  parameter int DIV_W     = 15,
  parameter int SEL_W     = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_CH-1:0]             in_clk,
  input logic [NUM_CH-1:0]             invert,
  input logic                          wr_en,
  input logic [1:0]                    wr_addr,
  input logic [SEL_W-1:0]              sel_q,
  input logic [NUM_CH-1:0][DIV_W-1:0]  div_q,
  input logic [NUM_CH-1:0]             out_pulse
);

  logic [NUM_CH-1:0] lvl_q;
  logic              armed_q;
  logic              hi_wr;

  assign hi_wr = wr_en && (wr_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      lvl_q   <= in_clk;
      armed_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8 / R7: a factor only moves on a high-byte commit aimed at this channel
    a_r8_store_hold: assert property (@(posedge clk) disable iff (rst)
      !(hi_wr && (sel_q == SEL_W'(c))) |=> $stable(div_q[c]));

    // R6: any divided pulse is preceded by an input edge one cycle earlier
    a_r6_pulse_needs_edge: assert property (@(posedge clk) disable iff (rst)
      (armed_q && out_pulse[c]) |-> $past(in_clk[c] ^ lvl_q[c]));
  end

  for (genvar c = 0; c < NUM_FIXED; c++) begin : g_fixed
    // R2 / R4: fixed channels mirror the selected edge one cycle later
    a_r2_fixed_follow: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> (out_pulse[c] ==
        $past(invert[c] ? (~in_clk[c] & lvl_q[c]) : (in_clk[c] & ~lvl_q[c]))));
  end

  // R12: a commit with an out-of-range select leaves the whole store alone
  a_r12_bad_sel_ignored: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && (int'(sel_q) >= NUM_CH)) |=> $stable(div_q));

endmodule

bind ref_prediv prediv_chk #(
  .NUM_CH    (NUM_CH),
  .NUM_FIXED (NUM_FIXED),
  .DIV_W     (DIV_W),
  .SEL_W     (SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_clk    (in_clk),
  .invert    (invert),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .sel_q     (sel_q),
  .div_q     (div_q),
  .out_pulse (out_pulse)
);

// File: tb/ref_prediv_bench.sv
module ref_prediv_bench;

  localparam int NUM_CH = 6;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [NUM_CH-1:0]      in_clk;
  logic [NUM_CH-1:0][3:0] freq_code;
  logic [1:0]             hf_sel_a, hf_sel_b;
  logic [NUM_CH-1:0]      use_divn, use_lock, invert;
  logic                   wr_en;
  logic [1:0]             wr_addr;
  logic [7:0]             wr_data;
  logic [NUM_CH-1:0]      out_pulse;

  int checks = 0;
  int errors = 0;
  int pulse_cnt [NUM_CH];
  bit check_req = 1'b0;
  int    q_ch  [$];
  int    q_exp [$];
  string q_tag [$];

  always #2 clk = ~clk;

  ref_prediv u_ref_prediv (
    .clk (clk), .rst (rst), .in_clk (in_clk), .freq_code (freq_code),
    .hf_sel_a (hf_sel_a), .hf_sel_b (hf_sel_b), .use_divn (use_divn),
    .use_lock (use_lock), .invert (invert), .wr_en (wr_en),
    .wr_addr (wr_addr), .wr_data (wr_data), .out_pulse (out_pulse)
  );

  // Monitor: counts pulses and, on request, pops and compares one expectation
  always @(negedge clk) begin
    int ch, ex;
    string tg;
    for (int c = 0; c < NUM_CH; c++)
      if (out_pulse[c] === 1'b1) pulse_cnt[c]++;
    if (check_req) begin
      ch = q_ch.pop_front();
      ex = q_exp.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (pulse_cnt[ch] != ex) begin
        errors++;
        $display("FAIL %s: channel %0d pulses actual %0d expected %0d", tg, ch, pulse_cnt[ch], ex);
      end
      for (int c = 0; c < NUM_CH; c++) pulse_cnt[c] = 0;
      check_req = 1'b0;
    end
  end

  task automatic expect_pulses(input int ch, input int ex, input string tg);
    q_ch.push_back(ch);
    q_exp.push_back(ex);
    q_tag.push_back(tg);
    @(posedge clk);
    check_req = 1'b1;
    while (check_req) @(posedge clk);
  endtask

  task automatic drive(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_clk[ch] = 1'b1;
      @(negedge clk);
      @(negedge clk); in_clk[ch] = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int ch, input int n, input int ex, input string tg);
    drive(ch, n);
    expect_pulses(ch, ex, tg);
  endtask

  task automatic set_lvl(input int ch, input logic v);
    @(negedge clk); in_clk[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load_div(input int ch, input logic [14:0] f);
    wr(2'd0, 8'(ch));
    wr(2'd1, f[7:0]);
    wr(2'd2, {1'b0, f[14:8]});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_clk = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    hf_sel_a = 2'b00; hf_sel_b = 2'b00;
    use_divn = '0; use_lock = '0; invert = '0;
    for (int c = 0; c < NUM_CH; c++) freq_code[c] = 4'h5;
    freq_code[0] = 4'h0; freq_code[1] = 4'h0;
    for (int c = 0; c < NUM_CH; c++) pulse_cnt[c] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: outputs quiet after reset
    checks++;
    if (out_pulse !== '0) begin
      errors++;
      $display("FAIL R1: out_pulse actual %b expected 0", out_pulse);
    end
    expect_pulses(2, 0, "R1 idle");

    // R1/R6: reset factor 0 passes every edge
    use_divn[2] = 1'b1;
    run(2, 3, 3, "R1 reset factor");

    // R7: three-step load, factor 3 -> divide by 4
    load_div(2, 15'd3);
    run(2, 8, 2, "R7 load");

    // R7: low byte alone leaves divide by 4
    wr(2'd1, 8'd1);
    run(2, 8, 2, "R7 low only");

    // R9: commit mid-period; old period finishes first
    run(2, 1, 1, "R9 start period");
    wr(2'd2, 8'd0);
    run(2, 3, 0, "R9 old period completes");
    run(2, 2, 1, "R9 first new period");
    run(2, 4, 2, "R9 steady new");

    // R8: other channel write leaves channel 2 at divide by 2
    load_div(3, 15'd2);
    run(2, 4, 2, "R8 other channel");
    use_divn[3] = 1'b1;
    run(3, 6, 2, "R8 channel 3 own factor");
    use_divn[3] = 1'b0;

    // R12: out-of-range select
    load_div(9, 15'd0);
    run(2, 4, 2, "R12 bad select");

    // R6: factor using the high byte, 259 -> divide by 260
    load_div(2, 15'h0103);
    run(2, 260, 1, "R6 wide factor");
    use_divn[2] = 1'b0;

    // R10: 48 kHz nominal -> divide by 6
    use_lock[3] = 1'b1;
    run(3, 12, 2, "R10 lock stage");

    // R11: both bits set -> programmable divider (factor 2)
    use_divn[3] = 1'b1;
    run(3, 6, 2, "R11 both set");
    use_divn[3] = 1'b0; use_lock[3] = 1'b0;
    run(3, 3, 3, "R11 neither set");

    // R5: prescaler codes on channel 4
    hf_sel_a = 2'b01;
    run(4, 8, 2, "R5 div4");
    hf_sel_a = 2'b10;
    run(4, 10, 2, "R5 div5");
    hf_sel_a = 2'b00;
    run(4, 3, 3, "R5 bypass");

    // R5/R6: prescaler then divider on channel 5
    hf_sel_b = 2'b01;
    load_div(5, 15'd1);
    use_divn[5] = 1'b1;
    run(5, 16, 2, "R5 R6 cascade");
    // R10: prescaler then 40 kHz lock stage -> divide by 20
    use_divn[5] = 1'b0; use_lock[5] = 1'b1;
    run(5, 40, 2, "R10 cascade lock");
    use_lock[5] = 1'b0; hf_sel_b = 2'b00;

    // R3: low-rate code bypasses prescaler
    freq_code[4] = 4'h1; hf_sel_a = 2'b01;
    run(4, 3, 3, "R3 low rate bypass");
    invert[4] = 1'b1;
    set_lvl(4, 1'b1);
    expect_pulses(4, 0, "R3 R4 rise ignored");
    set_lvl(4, 1'b0);
    expect_pulses(4, 1, "R3 R4 fall active");
    invert[4] = 1'b0; hf_sel_a = 2'b00; freq_code[4] = 4'h5;

    // R2: fixed channel ignores code and path bits
    freq_code[0] = 4'h5; use_divn[0] = 1'b1;
    run(0, 3, 3, "R2 fixed channel");
    use_divn[0] = 1'b0;

    // R4: invert on fixed channel
    invert[1] = 1'b1;
    set_lvl(1, 1'b1);
    expect_pulses(1, 0, "R4 rise ignored");
    set_lvl(1, 1'b0);
    expect_pulses(1, 1, "R4 fall active");
    invert[1] = 1'b0;

    // R4: invert has no effect outside bypass
    invert[2] = 1'b1;
    set_lvl(2, 1'b1);
    expect_pulses(2, 1, "R4 invert ignored");
    set_lvl(2, 1'b0);
    expect_pulses(2, 0, "R4 no fall pulse");
    invert[2] = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule